// File: doc/BRIEF.md
# DMA Receive Byte Packer Channel

This block is the receive half of a single DMA channel. A peripheral hands it one byte at a time. The block gathers the bytes into 32-bit words and sends them out as write requests on a simple memory-master port. When the current address is not word aligned, it writes early with byte or halfword accesses so that every access stays naturally aligned. It alternates between two buffer descriptors. Each descriptor holds a base byte address and a byte limit.

A buffer ends when the peripheral marks a byte as last, when it marks a byte as erroneous, or when the bytes taken reach the descriptor's limit. At that point the block writes out whatever the packer still holds, using the widest aligned accesses that fit. It never carries an access into the next buffer. It then records why the buffer ended, raises an interrupt that software clears by writing one, and flips an indicator that names the descriptor for the next buffer. The next buffer takes its start address from that descriptor's base when its first byte arrives. Its byte count starts again at zero.

Top module: `rxp_channel`

## Requirements
- R1: Once four bytes have gathered from a word-aligned address, a word write (wr_size_o = 2) is issued. Byte at address A travels on wr_data_o bits [8*(A mod 4)+7 : 8*(A mod 4)].
- R2: The packer writes before it is full when the address is not word aligned. At an odd address it issues a byte write (wr_size_o = 0) after one byte. At an address equal to 2 mod 4 it issues a halfword write (wr_size_o = 1) after two bytes. Every write is naturally aligned and stays within one word.
- R3: When a buffer ends, every pending byte is written whatever the alignment. The bytes go out in widest-first aligned pieces: at each step the size is the smaller of the alignment limit and the largest power of two not above the bytes left.
- R4: A byte flagged with rx_err_i ends the buffer. When ign_err_i is 0 that byte is dropped and not counted, and only the earlier bytes are written. When ign_err_i is 1 it is written like any other byte.
- R5: Each byte taken into the packer counts toward the current descriptor's limit. The byte that brings the count to the limit ends the buffer, and rx_tc_o is high for exactly one cycle, the cycle after that byte is accepted. rx_tc_o stays low for buffers ended by rx_last_i or rx_err_i.
- R6: At each buffer end, next_buf_o toggles (0 selects descriptor 0, 1 selects descriptor 1). The next buffer's first byte goes to the base of the newly selected descriptor, and its count restarts at zero.
- R7: At each buffer end, irq_o rises and cause_o is loaded (1 = last byte, 2 = error byte, 3 = limit reached). irq_o then stays high until a cycle with irq_clr_i high clears it.
- R8: A write request keeps wr_addr_o, wr_size_o and wr_data_o stable until the cycle wr_ready_i is seen. rx_ready_o is low while a write is outstanding or a buffer is being flushed.
- R9: All bytes written for a buffer land in [base, base + bytes kept). No write touches an address outside that range.
- R10: After reset, irq_o, rx_tc_o, wr_req_o and next_buf_o are 0, and rx_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base0_i | input | ADDR_W | Descriptor 0 base byte address |
| base1_i | input | ADDR_W | Descriptor 1 base byte address |
| max0_i | input | CNT_W | Descriptor 0 byte limit |
| max1_i | input | CNT_W | Descriptor 1 byte limit |
| ign_err_i | input | 1 | Keep the erroneous byte when set |
| rx_valid_i | input | 1 | Peripheral byte valid |
| rx_data_i | input | 8 | Peripheral byte |
| rx_last_i | input | 1 | Byte is the last of the stream |
| rx_err_i | input | 1 | Byte is erroneous and ends the stream |
| rx_ready_o | output | 1 | Byte accepted when high together with rx_valid_i |
| rx_tc_o | output | 1 | Byte limit reached pulse to the peripheral |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| wr_data_o | output | 32 | Write data on address-indexed byte lanes |
| wr_ready_i | input | 1 | Write accepted |
| irq_o | output | 1 | Buffer-end interrupt |
| irq_clr_i | input | 1 | Write-one-to-clear of the interrupt |
| cause_o | output | 2 | Cause of the last buffer end |
| next_buf_o | output | 1 | Descriptor to use for the next buffer |

## Verification
Suppose the packer's fill count is wrong. The per-size write counts go off within the same buffer, and bytes land on the wrong lanes or at addresses outside the buffer range. Suppose the address pointer or descriptor select is wrong. The very next buffer writes outside its expected region, and next_buf_o disagrees as soon as the interrupt rises. Errors in drop or count handling show up at that buffer's end, as a wrong byte total, a wrong cause or a missing rx_tc_o pulse. The sweep covers every start alignment, lengths from one to nine bytes, and every way a buffer can end.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned LANE_W    = $clog2(BUS_BYTES);
  localparam int unsigned FILL_W    = LANE_W + 1;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} wsize_e;
  typedef enum logic [1:0] {
    CS_NONE = 2'd0, CS_END = 2'd1, CS_ERR = 2'd2, CS_CNT = 2'd3
  } cause_e;
  typedef enum logic {ST_RUN = 1'b0, ST_FLUSH = 1'b1} st_e;

  function automatic wsize_e align_size(input logic [LANE_W-1:0] a);
    if (a[0]) return SZ_B;
    if (a[1]) return SZ_H;
    return SZ_W;
  endfunction

  function automatic logic [FILL_W-1:0] size_bytes(input wsize_e s);
    case (s)
      SZ_B:    return FILL_W'(1);
      SZ_H:    return FILL_W'(2);
      default: return FILL_W'(4);
    endcase
  endfunction

  // widest aligned piece not exceeding n bytes
  function automatic wsize_e fit_size(input logic [LANE_W-1:0] a,
                                      input logic [FILL_W-1:0] n);
    wsize_e al, nf;
    al = align_size(a);
    if (n >= FILL_W'(4))      nf = SZ_W;
    else if (n >= FILL_W'(2)) nf = SZ_H;
    else                      nf = SZ_B;
    return (nf < al) ? nf : al;
  endfunction
endpackage

// File: rtl/rxp_packer.sv
module rxp_packer
  import rxp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LANE_W-1:0]    ptr_i,
  input  logic                 push_i,
  input  logic [7:0]           byte_i,
  input  logic                 flush_i,
  input  logic                 wr_ready_i,
  output logic                 room_o,
  output logic                 empty_o,
  output logic                 wr_req_o,
  output wsize_e               wr_size_o,
  output logic [8*BUS_BYTES-1:0] wr_data_o,
  output logic                 done_o,
  output logic [FILL_W-1:0]    done_bytes_o
);
  logic [FILL_W-1:0] fill_q;
  logic              req_q;
  wsize_e            size_q;
  wsize_e            size_al, size_nx;
  logic              enough, issue;
  logic [LANE_W-1:0] lane;

  assign size_al = align_size(ptr_i);
  assign enough  = fill_q >= size_bytes(size_al);
  assign size_nx = flush_i ? fit_size(ptr_i, fill_q) : size_al;
  assign issue   = !req_q && (flush_i ? (fill_q != '0) : enough);
  assign lane    = ptr_i + fill_q[LANE_W-1:0];

  assign room_o       = !req_q && !enough;
  assign empty_o      = (fill_q == '0) && !req_q;
  assign done_o       = req_q && wr_ready_i;
  assign done_bytes_o = size_bytes(size_q);
  assign wr_req_o     = req_q;
  assign wr_size_o    = size_q;

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lane_q <= '0;
      else if (push_i && (lane == LANE_W'(k)))       lane_q <= byte_i;
    end
    assign wr_data_o[8*k +: 8] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      req_q  <= 1'b0;
      size_q <= SZ_B;
    end else begin
      if (push_i)      fill_q <= fill_q + FILL_W'(1);
      else if (done_o) fill_q <= fill_q - size_bytes(size_q);
      if (done_o)      req_q <= 1'b0;
      else if (issue) begin
        req_q  <= 1'b1;
        size_q <= size_nx;
      end
    end
  end
endmodule

// File: rtl/rxp_desc.sv
module rxp_desc
  import rxp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic [CNT_W-1:0]  max0_i,
  input  logic [CNT_W-1:0]  max1_i,
  input  logic              push_i,
  input  logic              adv_i,
  input  logic [FILL_W-1:0] adv_bytes_i,
  input  logic              term_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              at_limit_o,
  output logic              sel_o
);
  logic [ADDR_W-1:0] addr_q, base_cur;
  logic [CNT_W-1:0]  cnt_q, max_cur;
  logic              sel_q, fresh_q;

  assign base_cur   = sel_q ? base1_i : base0_i;
  assign max_cur    = sel_q ? max1_i : max0_i;
  // base is taken live until the first byte of a buffer lands
  assign ptr_o      = fresh_q ? base_cur : addr_q;
  assign at_limit_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, max_cur};
  assign sel_o      = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      fresh_q <= 1'b1;
    end else if (term_i) begin
      sel_q   <= ~sel_q;
      fresh_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      if (push_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (fresh_q) begin
          addr_q  <= base_cur;
          fresh_q <= 1'b0;
        end
      end
      if (adv_i) addr_q <= addr_q + ADDR_W'(adv_bytes_i);
    end
  end
endmodule

// File: rtl/rxp_status.sv
module rxp_status
  import rxp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   term_i,
  input  cause_e cause_i,
  input  logic   tc_set_i,
  input  logic   irq_clr_i,
  output logic   irq_o,
  output cause_e cause_o,
  output logic   tc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      cause_o <= CS_NONE;
      tc_o    <= 1'b0;
    end else begin
      tc_o <= tc_set_i;
      if (term_i) begin
        irq_o   <= 1'b1;
        cause_o <= cause_i;
      end else if (irq_clr_i) begin
        irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxp_channel.sv
module rxp_channel
  import rxp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic [CNT_W-1:0]  max0_i,
  input  logic [CNT_W-1:0]  max1_i,
  input  logic              ign_err_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  output logic              rx_ready_o,
  output logic              rx_tc_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [1:0]        wr_size_o,
  output logic [31:0]       wr_data_o,
  input  logic              wr_ready_i,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic [1:0]        cause_o,
  output logic              next_buf_o
);
  st_e               st_q;
  cause_e            pend_q, cause_s;
  logic [ADDR_W-1:0] ptr;
  logic              room, empty, done, at_limit, sel;
  logic              accept, keep, push, end_hit, cnt_hit, term;
  logic [FILL_W-1:0] done_bytes;
  wsize_e            size_s;

  assign rx_ready_o = (st_q == ST_RUN) && room;
  assign accept     = rx_valid_i && rx_ready_o;
  assign keep       = !(rx_err_i && !ign_err_i);
  assign push       = accept && keep;
  assign end_hit    = accept && (rx_last_i || rx_err_i);
  assign cnt_hit    = push && at_limit;
  assign term       = (st_q == ST_FLUSH) && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      pend_q <= CS_NONE;
    end else if (term) begin
      st_q <= ST_RUN;
    end else if (end_hit || cnt_hit) begin
      st_q   <= ST_FLUSH;
      pend_q <= rx_err_i ? CS_ERR : (rx_last_i ? CS_END : CS_CNT);
    end
  end

  rxp_packer u_packer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_i        (ptr[LANE_W-1:0]),
    .push_i       (push),
    .byte_i       (rx_data_i),
    .flush_i      (st_q == ST_FLUSH),
    .wr_ready_i   (wr_ready_i),
    .room_o       (room),
    .empty_o      (empty),
    .wr_req_o     (wr_req_o),
    .wr_size_o    (size_s),
    .wr_data_o    (wr_data_o),
    .done_o       (done),
    .done_bytes_o (done_bytes)
  );

  rxp_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base0_i     (base0_i),
    .base1_i     (base1_i),
    .max0_i      (max0_i),
    .max1_i      (max1_i),
    .push_i      (push),
    .adv_i       (done),
    .adv_bytes_i (done_bytes),
    .term_i      (term),
    .ptr_o       (ptr),
    .at_limit_o  (at_limit),
    .sel_o       (sel)
  );

  rxp_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .term_i    (term),
    .cause_i   (pend_q),
    .tc_set_i  (cnt_hit && !end_hit),
    .irq_clr_i (irq_clr_i),
    .irq_o     (irq_o),
    .cause_o   (cause_s),
    .tc_o      (rx_tc_o)
  );

  assign wr_addr_o  = ptr;
  assign wr_size_o  = size_s;
  assign cause_o    = cause_s;
  assign next_buf_o = sel;
endmodule

// File: rtl/rxp_channel_chk.sv
module rxp_channel_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_ready_o,
  input logic              rx_tc_o,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [1:0]        wr_size_o,
  input logic [31:0]       wr_data_o,
  input logic              wr_ready_i,
  input logic              irq_o,
  input logic              irq_clr_i,
  input logic              next_buf_o
);
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ready_i |=> wr_req_o && $stable(wr_addr_o)
                                && $stable(wr_size_o) && $stable(wr_data_o));

  a_r8_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !rx_ready_o);

  a_r2_natural: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_size_o != 2'd3) && (wr_size_o == 2'd0 || !wr_addr_o[0])
                 && (wr_size_o != 2'd2 || wr_addr_o[1:0] == 2'd0));

  a_r5_tc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tc_o |=> !rx_tc_o);

  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  a_r6_flip_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_buf_o != $past(next_buf_o)) |-> irq_o);
endmodule

bind rxp_channel rxp_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_ready_o (rx_ready_o),
  .rx_tc_o    (rx_tc_o),
  .wr_req_o   (wr_req_o),
  .wr_addr_o  (wr_addr_o),
  .wr_size_o  (wr_size_o),
  .wr_data_o  (wr_data_o),
  .wr_ready_i (wr_ready_i),
  .irq_o      (irq_o),
  .irq_clr_i  (irq_clr_i),
  .next_buf_o (next_buf_o)
);

// File: tb/tb_rxp_channel.sv
module tb_rxp_channel;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] base0_i = '0, base1_i = '0;
  logic [CW-1:0] max0_i = 16'd200, max1_i = 16'd200;
  logic          ign_err_i = 1'b0;
  logic          rx_valid_i = 1'b0, rx_last_i = 1'b0, rx_err_i = 1'b0;
  logic [7:0]    rx_data_i = '0;
  logic          rx_ready_o, rx_tc_o, wr_req_o, irq_o, next_buf_o;
  logic [AW-1:0] wr_addr_o;
  logic [1:0]    wr_size_o, cause_o;
  logic [31:0]   wr_data_o;
  logic          wr_ready_i = 1'b0, irq_clr_i = 1'b0;

  always #5 clk_i = ~clk_i;

  rxp_channel #(.ADDR_W(AW), .CNT_W(CW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] mem_b [512];
  bit         mem_w [512];
  int         cnt_sz [3];
  int         oob, tc_seen;
  int         lo, hi;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory responder with rotating latency
  initial begin
    int lat = 0, rot = 0;
    bit held = 0;
    logic [AW-1:0] h_a; logic [1:0] h_s; logic [31:0] h_d;
    forever begin
      @(negedge clk_i);
      if (wr_ready_i) wr_ready_i = 1'b0;
      else if (wr_req_o) begin
        chk(!rx_ready_o, "R8 ready low during write", int'(rx_ready_o), 0);
        if (held)
          chk(h_a == wr_addr_o && h_s == wr_size_o && h_d == wr_data_o,
              "R8 write held stable", int'(wr_addr_o), int'(h_a));
        else begin
          held = 1; h_a = wr_addr_o; h_s = wr_size_o; h_d = wr_data_o;
        end
        if (lat == 0) begin
          for (int k = 0; k < (1 << wr_size_o); k++) begin
            int a;
            a = int'(wr_addr_o) + k;
            if (a < lo || a >= hi) oob++;
            mem_b[a % 512] = wr_data_o[8*(a % 4) +: 8];
            mem_w[a % 512] = 1;
          end
          if (wr_size_o < 3) cnt_sz[wr_size_o]++;
          wr_ready_i = 1'b1;
          held = 0;
          rot = (rot + 1) % 3;
          lat = rot;
        end else lat--;
      end
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (rx_tc_o) tc_seen++;
  end

  task automatic send(input logic [7:0] d, input bit last, input bit err);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d; rx_last_i = last; rx_err_i = err;
    while (!rx_ready_o) @(negedge clk_i);
    @(posedge clk_i);
  endtask

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 37 + i * 11 + 5) & 255);
  endfunction

  // expected write sizes: widest aligned piece each step
  task automatic exp_walk(input int a, input int r, output int eb, output int eh, output int ew);
    eb = 0; eh = 0; ew = 0;
    while (r > 0) begin
      int al, nf, s;
      al = (a % 2 != 0) ? 1 : ((a % 4 != 0) ? 2 : 4);
      nf = (r >= 4) ? 4 : ((r >= 2) ? 2 : 1);
      s = (nf < al) ? nf : al;
      if (s == 1) eb++; else if (s == 2) eh++; else ew++;
      a += s; r -= s;
    end
  endtask

  initial begin
    int sel_exp = 0, bidx = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!irq_o, "R10 irq reset", int'(irq_o), 0);
    chk(!rx_tc_o, "R10 tc reset", int'(rx_tc_o), 0);
    chk(!wr_req_o, "R10 req reset", int'(wr_req_o), 0);
    chk(!next_buf_o, "R10 next_buf reset", int'(next_buf_o), 0);
    chk(rx_ready_o, "R10 ready reset", int'(rx_ready_o), 1);

    for (int al = 0; al < 4; al++)
      for (int len = 1; len <= 9; len++)
        for (int kind = 0; kind < 4; kind++) begin
          // kind: 0 last, 1 error dropped, 2 error kept, 3 limit
          int base, keep_n, eb, eh, ew, t, good;
          base = (sel_exp != 0) ? 32'h140 + al : 32'h40 + al;
          base0_i = AW'(32'h40 + al);
          base1_i = AW'(32'h140 + al);
          max0_i = (kind == 3 && sel_exp == 0) ? CW'(len) : CW'(200);
          max1_i = (kind == 3 && sel_exp == 1) ? CW'(len) : CW'(200);
          ign_err_i = (kind == 2);
          keep_n = (kind == 1) ? len - 1 : len;
          lo = base; hi = base + keep_n;
          for (int i = 0; i < 512; i++) mem_w[i] = 0;
          cnt_sz[0] = 0; cnt_sz[1] = 0; cnt_sz[2] = 0;
          oob = 0; tc_seen = 0;
          for (int i = 0; i < len; i++)
            send(pat(bidx, i), (kind == 0) && (i == len - 1),
                 (kind == 1 || kind == 2) && (i == len - 1));
          @(negedge clk_i);
          rx_valid_i = 1'b0; rx_last_i = 1'b0; rx_err_i = 1'b0;
          t = 0;
          while (!irq_o && t < 300) begin @(negedge clk_i); t++; end
          chk(irq_o, "R7 irq raised at end", int'(irq_o), 1);
          chk(int'(cause_o) == ((kind == 0) ? 1 : (kind == 3) ? 3 : 2),
              "R7 cause code", int'(cause_o), (kind == 0) ? 1 : (kind == 3) ? 3 : 2);
          chk(int'(next_buf_o) == 1 - sel_exp, "R6 next_buf toggles",
              int'(next_buf_o), 1 - sel_exp);
          exp_walk(base, keep_n, eb, eh, ew);
          chk(cnt_sz[2] == ew, "R1 word writes", cnt_sz[2], ew);
          chk(cnt_sz[1] == eh, "R2 halfword writes", cnt_sz[1], eh);
          chk(cnt_sz[0] == eb, "R3 byte writes", cnt_sz[0], eb);
          good = 0;
          for (int i = 0; i < keep_n; i++)
            if (mem_w[(base + i) % 512] && mem_b[(base + i) % 512] == pat(bidx, i)) good++;
          chk(good == keep_n, (kind == 1 || kind == 2) ? "R4 kept bytes" : "R3 flushed bytes",
              good, keep_n);
          chk(oob == 0, "R9 writes inside buffer", oob, 0);
          chk(tc_seen == ((kind == 3) ? 1 : 0), "R5 tc pulse count",
              tc_seen, (kind == 3) ? 1 : 0);
          repeat (3) @(negedge clk_i);
          chk(irq_o, "R7 irq held", int'(irq_o), 1);
          irq_clr_i = 1'b1;
          @(negedge clk_i);
          irq_clr_i = 1'b0;
          chk(!irq_o, "R7 irq cleared", int'(irq_o), 0);
          sel_exp = 1 - sel_exp;
          bidx++;
        end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule